// File: doc/BRIEF.md
# EDO DRAM Cycle Decoder

This block is the control core of an asynchronous extended-data-out DRAM with a 16-bit data path split into two byte lanes. A fast internal clock samples the active-low strobes (row strobe, lower and upper column strobes, write enable, output enable), the multiplexed address bus and the write data. Edges are found by comparing each sample with the one before it. From the order of these edges the block decides what kind of cycle is in progress: a plain row open, a read, an early or late write, a read-modify-write, a page access or a column-before-row refresh. It then steers a small register array and the per-lane output enables.

Read data is kept in a hold register that changes only when the column strobe falls again. This keeps the output valid through the column precharge, which is what distinguishes extended-data-out operation from fast page operation. A column-before-row cycle takes its row from an internal refresh counter instead of the address pins. Each row activation reports the refreshed row on a one-cycle pulse.

Top module: `edo_dram_core`

## Requirements
- R1: On a sampled falling edge of `ras_n` with no column strobe low in the previous sample, the row is taken from `addr[11:0]`. The column is taken from `addr[9:0]` at the falling edge of the merged column strobe. `cyc_type` reads 4 (row open, no access yet) after the row edge.
- R2: The merged column strobe is active while either `lcas_n` or `ucas_n` is low. A cycle does not end while one of them is still low, even if `ras_n` and the other strobe are high.
- R3: Lane 0 (`dout[7:0]`, `dq_oe[0]`) follows `lcas_n` and lane 1 (`dout[15:8]`, `dq_oe[1]`) follows `ucas_n`. Only the lanes whose strobe is low are written, and only those lanes are enabled on a read.
- R4: A read fetches data at the column strobe fall while `we_n` is high (`cyc_type` 1). The outputs turn on only once `oe_n` is also low, so the read effectively starts at the later of the two falls.
- R5: A write happens at the later of the column strobe fall and the `we_n` fall, using the data on `din` in that sample (`cyc_type` 2). A write that follows a read in the same row cycle reports `cyc_type` 3. Later changes of `din` have no effect.
- R6: If a column strobe was low in the sample before `ras_n` falls, the cycle is a refresh (`cyc_type` 5). Its row comes from the internal counter, `addr` is ignored, and `dq_oe` stays 0.
- R7: The refresh counter is 0 after reset, advances by one when each refresh cycle's `ras_n` rises, and wraps from 4095 to 0.
- R8: Read data and lane enables stay in place after the column strobe rises and change only at the next column strobe fall.
- R9: When `ras_n`, `lcas_n` and `ucas_n` are all high the cycle ends: `dq_oe` goes to 0 and `cyc_type` to 0.
- R10: Every `ras_n` fall raises `ref_pulse` for exactly one clock with `ref_row` set to the activated row. This covers row-only, read, write and refresh cycles.
- R11: After reset `dq_oe` is 0 and `cyc_type` is 0.
- R12: With `oe_n` high or `we_n` low, both `dq_oe` bits are 0 even while a column strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Lower-lane column strobe, active low |
| ucas_n | input | 1 | Upper-lane column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 12 | Multiplexed row/column address |
| din | input | 16 | Write data |
| dout | output | 16 | Held read data |
| dq_oe | output | 2 | Per-lane tristate enable, bit 0 lower lane |
| cyc_type | output | 3 | Cycle kind: 0 idle, 1 read, 2 write, 3 read-modify-write, 4 row open, 5 refresh |
| ref_pulse | output | 1 | One-clock pulse per row activation |
| ref_row | output | 12 | Row activated by the last pulse |

## Verification
The bench builds the block with its default geometry: a 12-bit row, a 10-bit column, 16 data bits, and a cell array of 4 rows by 8 columns selected by the low address bits. Because the array stays this small, every lane of a word can be written and read back within a few cycles. It also leaves room to walk the full 12-bit refresh counter through its wrap from 4095 to 0. The stimulus covers byte-lane masking, late output enable, late write, split strobe release and refresh address substitution.

// File: rtl/edo_pkg.sv
package edo_pkg;
   typedef enum logic [2:0] {
      CYC_IDLE    = 3'd0,
      CYC_READ    = 3'd1,
      CYC_WRITE   = 3'd2,
      CYC_RMW     = 3'd3,
      CYC_ROW     = 3'd4,
      CYC_REFRESH = 3'd5
   } edo_cyc_e;
endpackage

// File: rtl/edo_strobe_sampler.sv
module edo_strobe_sampler #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ras_n,
   input  logic [1:0]        cas_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic              ras_c,
   output logic              ras_p,
   output logic [1:0]        cas_c,
   output logic [1:0]        cas_p,
   output logic              we_c,
   output logic              we_p,
   output logic              oe_c,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] din_q
);
   // current sample and the one before it; strobes idle high
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ras_c  <= 1'b1;
         ras_p  <= 1'b1;
         cas_c  <= 2'b11;
         cas_p  <= 2'b11;
         we_c   <= 1'b1;
         we_p   <= 1'b1;
         oe_c   <= 1'b1;
         addr_q <= '0;
         din_q  <= '0;
      end else begin
         ras_c  <= ras_n;
         ras_p  <= ras_c;
         cas_c  <= cas_n;
         cas_p  <= cas_c;
         we_c   <= we_n;
         we_p   <= we_c;
         oe_c   <= oe_n;
         addr_q <= addr;
         din_q  <= din;
      end
   end
endmodule

// File: rtl/edo_refresh_counter.sv
module edo_refresh_counter #(
   parameter int ROW_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [ROW_W-1:0] count
);
   localparam logic [ROW_W-1:0] LAST = {ROW_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (inc)
         count <= (count == LAST) ? '0 : count + 1'b1;
   end
endmodule

// File: rtl/edo_cell_array.sv
module edo_cell_array #(
   parameter int DATA_W = 16,
   parameter int IDX_W  = 5
) (
   input  logic              clk,
   input  logic [1:0]        lane_we,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int WORDS  = 2 ** IDX_W;
   localparam int LANE_W = DATA_W / 2;

   logic [DATA_W-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      for (int ln = 0; ln < 2; ln++) begin
         if (lane_we[ln])
            mem[idx][ln*LANE_W +: LANE_W] <= wdata[ln*LANE_W +: LANE_W];
      end
   end

   assign rdata = mem[idx];
endmodule

// File: rtl/edo_dram_core.sv
module edo_dram_core
   import edo_pkg::*;
#(
   parameter int ROW_W        = 12,
   parameter int COL_W        = 10,
   parameter int DATA_W       = 16,
   parameter int ARR_ROW_BITS = 2,
   parameter int ARR_COL_BITS = 3,
   localparam int ADDR_W      = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ras_n,
   input  logic              lcas_n,
   input  logic              ucas_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic [1:0]        dq_oe,
   output logic [2:0]        cyc_type,
   output logic              ref_pulse,
   output logic [ROW_W-1:0]  ref_row
);
   localparam int IDX_W = ARR_ROW_BITS + ARR_COL_BITS;

   if (DATA_W < 2 || (DATA_W % 2) != 0) begin : g_bad_data
      $error("DATA_W must be even and at least 2");
   end
   if (ARR_ROW_BITS < 1 || ARR_ROW_BITS > ROW_W) begin : g_bad_row
      $error("ARR_ROW_BITS must lie in 1..ROW_W");
   end
   if (ARR_COL_BITS < 1 || ARR_COL_BITS > COL_W) begin : g_bad_col
      $error("ARR_COL_BITS must lie in 1..COL_W");
   end

   // sampled strobes
   logic              ras_c, ras_p, we_c, we_p, oe_c;
   logic [1:0]        cas_c, cas_p;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] din_q;

   edo_strobe_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_smp (
      .clk    (clk),
      .rst_n  (rst_n),
      .ras_n  (ras_n),
      .cas_n  ({ucas_n, lcas_n}),
      .we_n   (we_n),
      .oe_n   (oe_n),
      .addr   (addr),
      .din    (din),
      .ras_c  (ras_c),
      .ras_p  (ras_p),
      .cas_c  (cas_c),
      .cas_p  (cas_p),
      .we_c   (we_c),
      .we_p   (we_p),
      .oe_c   (oe_c),
      .addr_q (addr_q),
      .din_q  (din_q)
   );

   // edge decode
   logic cas_c_any, cas_p_any;
   logic ras_fall, ras_rise, cas_fall, we_fall, cycle_end;

   assign cas_c_any = ~&cas_c;
   assign cas_p_any = ~&cas_p;
   assign ras_fall  = ras_p & ~ras_c;
   assign ras_rise  = ~ras_p & ras_c;
   assign cas_fall  = cas_c_any & ~cas_p_any;
   assign we_fall   = we_p & ~we_c;
   assign cycle_end = ras_c & ~cas_c_any;

   // cycle state
   edo_cyc_e                cyc_q;
   logic                    open_q, cbr_q;
   logic [ARR_ROW_BITS-1:0] row_q;
   logic [ARR_COL_BITS-1:0] col_q, col_sel;
   logic [DATA_W-1:0]       hold_q, rdata;
   logic [1:0]              lane_on, lane_we;
   logic [ROW_W-1:0]        ctr_row;
   logic                    access, rd_ev, wr_ev, ctr_inc;

   assign col_sel = cas_fall ? addr_q[ARR_COL_BITS-1:0] : col_q;
   assign access  = open_q & ~ras_c;
   assign rd_ev   = access & cas_fall & we_c;
   assign wr_ev   = access & cas_c_any & ~we_c & (cas_fall | we_fall);
   assign lane_we = wr_ev ? ~cas_c : 2'b00;
   assign ctr_inc = ras_rise & cbr_q;

   edo_refresh_counter #(.ROW_W(ROW_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (ctr_inc),
      .count (ctr_row)
   );

   edo_cell_array #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_arr (
      .clk     (clk),
      .lane_we (lane_we),
      .idx     ({row_q, col_sel}),
      .wdata   (din_q),
      .rdata   (rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_q     <= CYC_IDLE;
         open_q    <= 1'b0;
         cbr_q     <= 1'b0;
         row_q     <= '0;
         col_q     <= '0;
         hold_q    <= '0;
         lane_on   <= 2'b00;
         ref_pulse <= 1'b0;
         ref_row   <= '0;
      end else begin
         ref_pulse <= 1'b0;
         if (ras_fall) begin
            ref_pulse <= 1'b1;
            if (cas_p_any) begin
               cbr_q   <= 1'b1;
               ref_row <= ctr_row;
               cyc_q   <= CYC_REFRESH;
            end else begin
               open_q  <= 1'b1;
               row_q   <= addr_q[ARR_ROW_BITS-1:0];
               ref_row <= addr_q[ROW_W-1:0];
               cyc_q   <= CYC_ROW;
            end
         end
         if (ras_rise) begin
            open_q <= 1'b0;
            cbr_q  <= 1'b0;
         end
         if (rd_ev) begin
            col_q   <= addr_q[ARR_COL_BITS-1:0];
            hold_q  <= rdata;
            lane_on <= ~cas_c;
            cyc_q   <= CYC_READ;
         end
         if (wr_ev) begin
            if (cas_fall)
               col_q <= addr_q[ARR_COL_BITS-1:0];
            lane_on <= 2'b00;
            cyc_q   <= (cyc_q == CYC_READ || cyc_q == CYC_RMW) ? CYC_RMW : CYC_WRITE;
         end
         if (cycle_end) begin
            cyc_q   <= CYC_IDLE;
            lane_on <= 2'b00;
         end
      end
   end

   for (genvar ln = 0; ln < 2; ln++) begin : g_lane
      assign dq_oe[ln] = lane_on[ln] & ~oe_c & we_c;
   end

   assign dout     = hold_q;
   assign cyc_type = cyc_q;
endmodule

module edo_dram_core_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       ras_n,
   input logic       lcas_n,
   input logic       ucas_n,
   input logic       we_n,
   input logic       oe_n,
   input logic [1:0] dq_oe,
   input logic [2:0] cyc_type,
   input logic       ref_pulse
);
   AST_IDLE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
      (ras_n && lcas_n && ucas_n) |-> ##2 (dq_oe == 2'b00)); // R9
   AST_IDLE_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
      (ras_n && lcas_n && ucas_n) |-> ##2 (cyc_type == 3'd0)); // R9
   AST_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |=> (dq_oe == 2'b00)); // R12
   AST_WE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |=> (dq_oe == 2'b00)); // R12
   AST_REFRESH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_type == 3'd5 && $past(cyc_type) == 3'd0) |-> (dq_oe == 2'b00)); // R6
   AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_type == 3'd2) |-> (dq_oe == 2'b00)); // R5
   AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      ref_pulse |=> !ref_pulse); // R10
endmodule

bind edo_dram_core edo_dram_core_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ras_n     (ras_n),
   .lcas_n    (lcas_n),
   .ucas_n    (ucas_n),
   .we_n      (we_n),
   .oe_n      (oe_n),
   .dq_oe     (dq_oe),
   .cyc_type  (cyc_type),
   .ref_pulse (ref_pulse)
);

// File: tb/edo_dram_core_bench.sv
`timescale 1ns/1ps
module edo_dram_core_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ras_n = 1'b1, lcas_n = 1'b1, ucas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [11:0] addr = '0;
   logic [15:0] din = '0;
   logic [15:0] dout;
   logic [1:0]  dq_oe;
   logic [2:0]  cyc_type;
   logic        ref_pulse;
   logic [11:0] ref_row;

   int n_chk = 0;
   int n_fail = 0;
   int n_pulse = 0;
   logic [11:0] last_ref = '0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   edo_dram_core u_edo_dram_core (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
      .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din), .dout(dout),
      .dq_oe(dq_oe), .cyc_type(cyc_type), .ref_pulse(ref_pulse), .ref_row(ref_row)
   );

   always @(negedge clk) begin
      if (ref_pulse) begin
         last_ref <= ref_row;
         n_pulse  <= n_pulse + 1;
      end
   end

   typedef struct packed {
      logic        r, l, u, w, o;
      logic [11:0] a;
      logic [15:0] d;
      logic [1:0]  eoe;
      logic        chk;
      logic [15:0] edout;
      logic [2:0]  etype;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t TBL [NV] = '{
      '{1,1,1,1,1, 12'h000, 16'h0000, 2'b00, 0, 16'h0000, 3'd0, 4'd9},  // R9 idle
      '{0,1,1,1,1, 12'h005, 16'h0000, 2'b00, 0, 16'h0000, 3'd4, 4'd1},  // R1 row open
      '{0,0,0,0,1, 12'h003, 16'hA5A5, 2'b00, 0, 16'h0000, 3'd2, 4'd5},  // R5 early write
      '{0,1,1,1,1, 12'h003, 16'hA5A5, 2'b00, 0, 16'h0000, 3'd2, 4'd5},
      '{1,1,1,1,1, 12'h000, 16'h0000, 2'b00, 0, 16'h0000, 3'd0, 4'd9},  // R9
      '{0,1,1,1,1, 12'h005, 16'h0000, 2'b00, 0, 16'h0000, 3'd4, 4'd1},
      '{0,0,0,1,0, 12'h003, 16'h0000, 2'b11, 1, 16'hA5A5, 3'd1, 4'd1},  // R1 read back
      '{0,1,1,1,0, 12'h003, 16'h0000, 2'b11, 1, 16'hA5A5, 3'd1, 4'd8},  // R8 hold past CAS rise
      '{1,1,1,1,0, 12'h000, 16'h0000, 2'b00, 0, 16'h0000, 3'd0, 4'd9},  // R9 end with OE low
      '{0,1,1,1,1, 12'h005, 16'h0000, 2'b00, 0, 16'h0000, 3'd4, 4'd1},
      '{0,1,0,0,1, 12'h003, 16'h3CFF, 2'b00, 0, 16'h0000, 3'd2, 4'd3},  // R3 upper byte write
      '{1,1,1,1,1, 12'h000, 16'h0000, 2'b00, 0, 16'h0000, 3'd0, 4'd9},
      '{0,1,1,1,1, 12'h005, 16'h0000, 2'b00, 0, 16'h0000, 3'd4, 4'd1},
      '{0,0,1,1,0, 12'h003, 16'h0000, 2'b01, 1, 16'h3CA5, 3'd1, 4'd3},  // R3 lower lane read
      '{1,1,1,1,1, 12'h000, 16'h0000, 2'b00, 0, 16'h0000, 3'd0, 4'd9},
      '{0,1,1,1,1, 12'h005, 16'h0000, 2'b00, 0, 16'h0000, 3'd4, 4'd1},
      '{0,0,0,1,1, 12'h003, 16'h0000, 2'b00, 0, 16'h0000, 3'd1, 4'd4},  // R4 CAS with OE high
      '{0,0,0,1,0, 12'h003, 16'h0000, 2'b11, 1, 16'h3CA5, 3'd1, 4'd4},  // R4 late OE
      '{1,1,1,1,1, 12'h000, 16'h0000, 2'b00, 0, 16'h0000, 3'd0, 4'd9}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drv(input logic r, l, u, w, o, input logic [11:0] a, input logic [15:0] d);
      ras_n = r; lcas_n = l; ucas_n = u; we_n = w; oe_n = o; addr = a; din = d;
      repeat (3) @(negedge clk);
   endtask

   task automatic idle();
      drv(1,1,1,1,1, 12'h000, 16'h0000);
   endtask

   task automatic refresh_cycle();
      drv(1,0,0,1,1, 12'hABC, 16'h0000);
      drv(0,0,0,1,1, 12'hABC, 16'h0000);
      drv(1,1,1,1,1, 12'h000, 16'h0000);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      int p0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check("R11 dq_oe", {30'd0, dq_oe}, 32'd0);
      check("R11 cyc_type", {29'd0, cyc_type}, 32'd0);

      // vector table
      for (int i = 0; i < NV; i++) begin
         drv(TBL[i].r, TBL[i].l, TBL[i].u, TBL[i].w, TBL[i].o, TBL[i].a, TBL[i].d);
         check($sformatf("R%0d row %0d dq_oe", TBL[i].req, i), {30'd0, dq_oe}, {30'd0, TBL[i].eoe});
         check($sformatf("R%0d row %0d type", TBL[i].req, i), {29'd0, cyc_type}, {29'd0, TBL[i].etype});
         if (TBL[i].chk)
            check($sformatf("R%0d row %0d dout", TBL[i].req, i), {16'd0, dout}, {16'd0, TBL[i].edout});
      end

      // R2 split strobe release keeps cycle alive
      drv(0,1,1,1,1, 12'h005, 16'h0000);
      drv(0,0,0,1,0, 12'h003, 16'h0000);
      drv(1,1,0,1,0, 12'h003, 16'h0000);
      check("R2 upper low keeps outputs", {30'd0, dq_oe}, 32'd3);
      check("R2 upper low keeps type", {29'd0, cyc_type}, 32'd1);
      drv(1,1,1,1,0, 12'h003, 16'h0000);
      check("R2 last strobe high ends", {30'd0, dq_oe}, 32'd0);

      // R12 OE high during an active read
      drv(0,1,1,1,1, 12'h005, 16'h0000);
      drv(0,0,0,1,0, 12'h003, 16'h0000);
      check("R12 on before OE rise", {30'd0, dq_oe}, 32'd3);
      drv(0,0,0,1,1, 12'h003, 16'h0000);
      check("R12 OE high gates off", {30'd0, dq_oe}, 32'd0);
      idle();

      // R5 late write and read-modify-write, din change afterwards ignored
      drv(0,1,1,1,1, 12'h009, 16'h0000);
      drv(0,0,0,1,1, 12'h005, 16'h1111);
      check("R5 read phase type", {29'd0, cyc_type}, 32'd1);
      drv(0,0,0,0,1, 12'h005, 16'h7E81);
      check("R5 rmw type", {29'd0, cyc_type}, 32'd3);
      drv(0,0,0,0,1, 12'h005, 16'h0000);
      idle();
      drv(0,1,1,1,1, 12'h009, 16'h0000);
      drv(0,0,0,1,0, 12'h005, 16'h0000);
      check("R5 late write data", {16'd0, dout}, {16'd0, 16'h7E81});
      idle();

      // R10 row-only pulse carries full 12-bit row
      p0 = n_pulse;
      drv(0,1,1,1,1, 12'h7AB, 16'h0000);
      check("R10 pulse count", n_pulse - p0, 32'd1);
      check("R10 ref_row", {20'd0, last_ref}, {20'd0, 12'h7AB});
      idle();

      // R6 and R7 refresh cycles
      p0 = n_pulse;
      drv(1,0,0,1,1, 12'hABC, 16'h0000);
      drv(0,0,0,1,1, 12'hABC, 16'h0000);
      check("R6 refresh type", {29'd0, cyc_type}, 32'd5);
      check("R6 refresh outputs off", {30'd0, dq_oe}, 32'd0);
      check("R7 first refresh row zero", {20'd0, last_ref}, 32'd0);
      check("R6 refresh pulse", n_pulse - p0, 32'd1);
      idle();
      refresh_cycle();
      check("R7 second refresh row", {20'd0, last_ref}, 32'd1);
      for (int k = 2; k < 4096; k++) refresh_cycle();
      check("R7 last row before wrap", {20'd0, last_ref}, 32'd4095);
      refresh_cycle();
      check("R7 wrap to zero", {20'd0, last_ref}, 32'd0);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule